// File: doc/BRIEF.md
# Descriptor-Driven Configuration Copy Engine

This block copies bytes out of a firmware configuration store into system memory. Software picks an item through a selector register. It can then read the item one byte at a time through a data window. For bulk transfers, it writes the memory address of a 16-byte request record into a pointer register.

When the last pointer byte is written, the engine reads the record from memory. The record holds a target address, a byte count and a control word, and each field is stored most significant byte first. The engine then moves the requested bytes from the current item position to the target address.

At the end it writes back the updated target address, the remaining count and a status word over the same record. Status zero means success. Status 1 (bit 0 set) means failure, and in that case the address and count that come back show how far the copy got.

The item contents are supplied from outside through a byte lookup port that carries the selector and the current offset. Memory is reached through a byte-wide request/acknowledge port with an error response.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset `busy` and `mem_req` are 0 and `item_off` is 0.
- R2: Register bytes 10 to 17 hold the 64-bit record pointer, most significant byte at 10. A write to byte 17 while idle starts an operation, and `busy` is 1 from the cycle after that write.
- R3: The record is read as 16 single-byte reads at pointer+0 to pointer+15. Bytes 0–7 hold the target address, bytes 8–11 the count and bytes 12–15 the control word, each field most significant byte first. A request holds its address and direction until acknowledged.
- R4: With control value 2 and a nonzero target, the engine writes `count` item bytes, taken from the current offset upward, to ascending addresses starting at the target.
- R5: The write-back is 16 byte writes to pointer+0 to pointer+15 in the same layout. On success it carries target+count, count 0 and control 0, after which `busy` returns to 0.
- R6: A target of zero is a skip: no memory writes occur before the write-back, the offset still advances by the count, and the address written back is 0.
- R7: If the item ends (offset reaches `item_size`) with count left, the copy stops. The write-back carries control 1 and the address and count reached so far.
- R8: An error response to a copy write stops the copy with control 1. That byte is not counted, and neither the address, the count nor the offset advances for it.
- R9: A control value other than 2 moves no data and writes back the original address and count with control 1.
- R10: Pointer writes while `busy` is 1 neither start a new operation nor change the latched pointer.
- R11: Writing either selector byte (8 = high byte, 9 = low byte) sets the item offset to 0.
- R12: A read at register bytes 0–7 returns, on `reg_rdata` in the next cycle, the item byte at the offset and advances the offset by 1. When the offset is at or past the item end, it returns 0 and leaves the offset unchanged.
- R13: After an operation the offset equals its starting value plus the bytes copied or skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_rd | input | 1 | Register byte read strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Data window read byte, valid the cycle after `reg_rd` |
| busy | output | 1 | Operation in progress |
| item_sel | output | 16 | Selected configuration item |
| item_off | output | 32 | Current byte offset within the item |
| item_byte | input | 8 | Item byte at `item_sel`/`item_off` |
| item_size | input | 32 | Size in bytes of the selected item |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle request completion |
| mem_err | input | 1 | Error response, valid with `mem_ack` |

## Verification
The bench builds the engine with its default widths: a full 64-bit pointer, a 16-bit selector and 32-bit count and control fields. Items are kept to between 24 and 31 bytes. That makes running off the end of an item reachable within a short copy, and lets a skip land the offset exactly on the item end, so the past-the-end data read can be checked. Pointers with every byte distinct, an injected write error at a chosen address, and pointer writes issued mid-transfer cover the byte ordering, the partial-progress write-back and the busy lockout.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_COPY,
    S_CWAIT,
    S_WB
  } seq_state_e;

  localparam int CTRL_READ = 2;

endpackage

// File: rtl/cfg_dma_cursor.sv
module cfg_dma_cursor #(
  parameter int OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [OFF_W-1:0] size_i,
  output logic [OFF_W-1:0] off_o,
  output logic             avail_o
);

  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
    end else if (clr_i) begin
      off_q <= '0;
    end else if (inc_i) begin
      off_q <= off_q + 1'b1;
    end
  end

  assign off_o   = off_q;
  assign avail_o = off_q < size_i;

  // R11
  sel_clears_off_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> off_o == '0);

  // R13
  off_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i) |=> off_o == $past(off_o) + 1'b1);

endmodule

// File: rtl/cfg_dma_regs.sv
module cfg_dma_regs #(
  parameter int ADDR_W = 64,
  parameter int SEL_W  = 16,
  parameter int RA_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              busy_i,
  input  logic [7:0]        item_byte_i,
  input  logic              item_avail_i,
  output logic [7:0]        reg_rdata_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              start_o,
  output logic              off_clr_o,
  output logic              off_inc_o
);

  localparam int DATA_B   = 8;
  localparam int SEL_B    = SEL_W / 8;
  localparam int PTR_B    = ADDR_W / 8;
  localparam int SEL_LO   = DATA_B;
  localparam int PTR_LO   = DATA_B + SEL_B;
  localparam int PTR_LAST = PTR_LO + PTR_B - 1;

  logic [ADDR_W-1:0] ptr_q;
  logic [SEL_W-1:0]  sel_q;
  logic              start_q;
  logic [7:0]        rdata_q;
  logic              hit_data;
  logic              hit_sel;

  assign hit_data = reg_addr < RA_W'(DATA_B);
  assign hit_sel  = (reg_addr >= RA_W'(SEL_LO)) && (reg_addr < RA_W'(PTR_LO));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      sel_q   <= '0;
      start_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (reg_wr) begin
        for (int k = 0; k < SEL_B; k++) begin
          if (reg_addr == RA_W'(SEL_LO + k)) begin
            sel_q[8*(SEL_B-1-k) +: 8] <= reg_wdata;
          end
        end
        if (!busy_i) begin
          for (int k = 0; k < PTR_B; k++) begin
            if (reg_addr == RA_W'(PTR_LO + k)) begin
              ptr_q[8*(PTR_B-1-k) +: 8] <= reg_wdata;
            end
          end
          if (reg_addr == RA_W'(PTR_LAST)) begin
            start_q <= 1'b1;
          end
        end
      end
      if (reg_rd && hit_data) begin
        rdata_q <= item_avail_i ? item_byte_i : 8'h00;
      end
    end
  end

  assign reg_rdata_o = rdata_q;
  assign sel_o       = sel_q;
  assign ptr_o       = ptr_q;
  assign start_o     = start_q;
  assign off_clr_o   = reg_wr && hit_sel;
  assign off_inc_o   = reg_rd && hit_data && item_avail_i;

  // R10
  busy_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_i && reg_wr) |=> !start_o);

  // R10
  busy_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(ptr_o));

endmodule

// File: rtl/cfg_dma_seq.sv
module cfg_dma_seq
  import cfg_dma_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [7:0]        item_byte_i,
  input  logic              item_avail_i,
  output logic              adv_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i
);

  localparam int DESC_W = ADDR_W + LEN_W + CTRL_W;
  localparam int DESC_B = DESC_W / 8;
  localparam int CNT_W  = $clog2(DESC_B);

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] ptr_q;
  logic [DESC_W-9:0] shreg;
  logic [ADDR_W-1:0] tgt_q;
  logic [LEN_W-1:0]  len_q;
  logic              err_q;
  logic              req_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;

  logic [DESC_W-1:0] fetched;
  logic [DESC_W-1:0] wb_vec;
  logic [7:0]        wb_byte;
  logic [ADDR_W-1:0] rec_addr;
  logic              cnt_last;
  logic [ADDR_W-1:0] f_tgt;
  logic [LEN_W-1:0]  f_len;
  logic [CTRL_W-1:0] f_ctrl;

  assign fetched  = {shreg, mem_rdata_i};
  assign f_tgt    = fetched[DESC_W-1 -: ADDR_W];
  assign f_len    = fetched[LEN_W+CTRL_W-1 -: LEN_W];
  assign f_ctrl   = fetched[CTRL_W-1:0];
  assign wb_vec   = {tgt_q, len_q, {{(CTRL_W-1){1'b0}}, err_q}};
  assign rec_addr = ptr_q + {{(ADDR_W-CNT_W){1'b0}}, cnt};
  assign cnt_last = cnt == CNT_W'(DESC_B - 1);

  always_comb begin
    wb_byte = wb_vec[8*(DESC_B-1-int'(cnt)) +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      ptr_q   <= '0;
      shreg   <= '0;
      tgt_q   <= '0;
      len_q   <= '0;
      err_q   <= 1'b0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start_i) begin
            ptr_q <= ptr_i;
            cnt   <= '0;
            err_q <= 1'b0;
            state <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (!req_q) begin
            req_q  <= 1'b1;
            we_q   <= 1'b0;
            addr_q <= rec_addr;
          end else if (mem_ack_i) begin
            req_q <= 1'b0;
            if (mem_err_i) begin
              state <= S_IDLE;
            end else begin
              shreg <= fetched[DESC_W-9:0];
              cnt   <= cnt + 1'b1;
              if (cnt_last) begin
                tgt_q <= f_tgt;
                len_q <= f_len;
                if (f_ctrl != CTRL_W'(CTRL_READ)) begin
                  err_q <= 1'b1;
                  state <= S_WB;
                end else begin
                  state <= S_COPY;
                end
              end
            end
          end
        end
        S_COPY: begin
          if (len_q == '0) begin
            cnt   <= '0;
            state <= S_WB;
          end else if (!item_avail_i) begin
            err_q <= 1'b1;
            cnt   <= '0;
            state <= S_WB;
          end else if (tgt_q == '0) begin
            len_q <= len_q - 1'b1;
          end else begin
            req_q   <= 1'b1;
            we_q    <= 1'b1;
            addr_q  <= tgt_q;
            wdata_q <= item_byte_i;
            state   <= S_CWAIT;
          end
        end
        S_CWAIT: begin
          if (mem_ack_i) begin
            req_q <= 1'b0;
            if (mem_err_i) begin
              err_q <= 1'b1;
              cnt   <= '0;
              state <= S_WB;
            end else begin
              tgt_q <= tgt_q + 1'b1;
              len_q <= len_q - 1'b1;
              state <= S_COPY;
            end
          end
        end
        S_WB: begin
          if (!req_q) begin
            req_q   <= 1'b1;
            we_q    <= 1'b1;
            addr_q  <= rec_addr;
            wdata_q <= wb_byte;
          end else if (mem_ack_i) begin
            req_q <= 1'b0;
            cnt   <= cnt + 1'b1;
            if (cnt_last) begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign adv_o = (state == S_COPY && len_q != '0 && item_avail_i && tgt_q == '0) ||
                 (state == S_CWAIT && mem_ack_i && !mem_err_i);
  assign busy_o      = state != S_IDLE;
  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R4
  len_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_CWAIT && mem_ack_i && !mem_err_i) |=> len_q == $past(len_q) - 1'b1);

  // R6
  skip_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_CWAIT && mem_req_o) |-> mem_addr_o != '0);

  // R7
  exhaust_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_COPY && len_q != '0 && !item_avail_i) |=> (err_q && state == S_WB));

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> state == S_IDLE);

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int CTRL_W = 32,
  parameter int SEL_W  = 16,
  parameter int OFF_W  = 32,
  parameter int RA_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              busy,
  output logic [SEL_W-1:0]  item_sel,
  output logic [OFF_W-1:0]  item_off,
  input  logic [7:0]        item_byte,
  input  logic [OFF_W-1:0]  item_size,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);

  logic [ADDR_W-1:0] ptr;
  logic              start;
  logic              off_clr;
  logic              rd_inc;
  logic              dma_inc;
  logic              avail;
  logic              seq_busy;

  assign busy = seq_busy | start;

  cfg_dma_regs #(
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W),
    .RA_W   (RA_W)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .busy_i       (busy),
    .item_byte_i  (item_byte),
    .item_avail_i (avail),
    .reg_rdata_o  (reg_rdata),
    .sel_o        (item_sel),
    .ptr_o        (ptr),
    .start_o      (start),
    .off_clr_o    (off_clr),
    .off_inc_o    (rd_inc)
  );

  cfg_dma_cursor #(
    .OFF_W (OFF_W)
  ) u_cursor (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (off_clr),
    .inc_i   (rd_inc | dma_inc),
    .size_i  (item_size),
    .off_o   (item_off),
    .avail_o (avail)
  );

  cfg_dma_seq #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .CTRL_W (CTRL_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .ptr_i        (ptr),
    .item_byte_i  (item_byte),
    .item_avail_i (avail),
    .adv_o        (dma_inc),
    .busy_o       (seq_busy),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_rdata_i  (mem_rdata),
    .mem_ack_i    (mem_ack),
    .mem_err_i    (mem_err)
  );

endmodule

// File: tb/cfg_dma_engine_bench.sv
`timescale 1ns/1ps
module cfg_dma_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        busy;
  logic [15:0] item_sel;
  logic [31:0] item_off;
  logic [7:0]  item_byte;
  logic [31:0] item_size;
  logic        mem_req;
  logic        mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [7:0]  mem [logic [63:0]];
  logic [71:0] exp_wq[$];
  logic        inj_en = 1'b0;
  logic [63:0] inj_addr = '0;
  logic [15:0] m_sel = '0;
  logic [31:0] m_off = '0;

  always #2.5 clk = ~clk;

  cfg_dma_engine u_cfg_dma_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .item_sel(item_sel),
    .item_off(item_off), .item_byte(item_byte), .item_size(item_size),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err)
  );

  function automatic logic [7:0] item_val(logic [15:0] s, logic [31:0] o);
    int v;
    v = int'(s) * 13 + int'(o) * 5 + 1;
    return v[7:0];
  endfunction

  function automatic logic [31:0] size_of(logic [15:0] s);
    return 32'd24 + {29'd0, s[2:0]};
  endfunction

  assign item_size = size_of(item_sel);
  assign item_byte = (item_off < item_size) ? item_val(item_sel, item_off) : 8'hEE;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory responder: registered acknowledge, every write compared to the model queue.
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_err <= 1'b0;
      if (mem_we) begin
        if (exp_wq.size() == 0) begin
          chk("R4 unexpected write addr", mem_addr, 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          logic [71:0] e;
          e = exp_wq.pop_front();
          chk("R4/R5 write addr", mem_addr, e[71:8]);
          chk("R4/R5 write data", {56'd0, mem_wdata}, {56'd0, e[7:0]});
        end
        if (inj_en && mem_addr == inj_addr) mem_err <= 1'b1;
        else mem[mem_addr] = mem_wdata;
      end else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
      end
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic reg_write(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_sel(logic [15:0] s);
    reg_write(5'd8, s[15:8]);
    reg_write(5'd9, s[7:0]);
    m_sel = s;
    m_off = '0;
  endtask

  task automatic data_read(output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 5'd3;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic write_ptr(logic [63:0] p);
    for (int i = 0; i < 8; i++) reg_write(5'(10 + i), p[8*(7-i) +: 8]);
  endtask

  task automatic put_rec(logic [63:0] p, logic [63:0] t, logic [31:0] l, logic [31:0] c);
    logic [127:0] v;
    v = {t, l, c};
    for (int i = 0; i < 16; i++) mem[p + 64'(i)] = v[8*(15-i) +: 8];
  endtask

  function automatic logic [127:0] get_rec(logic [63:0] p);
    logic [127:0] v;
    for (int i = 0; i < 16; i++)
      v[8*(15-i) +: 8] = mem.exists(p + 64'(i)) ? mem[p + 64'(i)] : 8'h00;
    return v;
  endfunction

  task automatic run_xfer(string tag, logic [63:0] p, logic [63:0] t, logic [31:0] l,
                          logic [31:0] c, logic poke, logic [63:0] p2);
    logic [63:0]  a;
    logic [31:0]  n;
    logic         e;
    logic [127:0] v;
    a = t; n = l; e = 1'b0;
    if (c != 32'd2) e = 1'b1;
    else begin
      while (n != 0) begin
        if (m_off >= size_of(m_sel)) begin e = 1'b1; break; end
        if (a != 0) begin
          exp_wq.push_back({a, item_val(m_sel, m_off)});
          if (inj_en && a == inj_addr) begin e = 1'b1; break; end
          a = a + 1;
        end
        m_off = m_off + 1;
        n = n - 1;
      end
    end
    v = {a, n, {31'd0, e}};
    for (int i = 0; i < 16; i++) exp_wq.push_back({p + 64'(i), v[8*(15-i) +: 8]});
    put_rec(p, t, l, c);
    write_ptr(p);
    chk({tag, " R2 busy after start"}, {63'd0, busy}, 64'd1);
    if (poke) write_ptr(p2);
    while (busy) @(negedge clk);
    if (poke) repeat (60) @(negedge clk);
    chk({tag, " R5 all writes seen"}, 64'(exp_wq.size()), 64'd0);
    v = get_rec(p);
    chk({tag, " R5 addr field"}, v[127:64], a);
    chk({tag, " R5 len field"}, {32'd0, v[63:32]}, {32'd0, n});
    chk({tag, " R5 ctrl field"}, {32'd0, v[31:0]}, {63'd0, e});
    chk({tag, " R13 offset"}, {32'd0, item_off}, {32'd0, m_off});
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 mem_req", {63'd0, mem_req}, 64'd0);
    chk("R1 offset", {32'd0, item_off}, 64'd0);

    // R11, R12 data window reads
    set_sel(16'h0003);
    chk("R11 offset cleared", {32'd0, item_off}, 64'd0);
    for (int i = 0; i < 3; i++) begin
      data_read(d);
      chk("R12 data byte", {56'd0, d}, {56'd0, item_val(16'h0003, 32'(i))});
      m_off = m_off + 1;
    end
    chk("R12 offset after reads", {32'd0, item_off}, 64'd3);

    // R2 R3 R4 normal copy with a pointer of distinct bytes
    run_xfer("R4 copy", 64'h0123_4567_89AB_0100, 64'h2000, 32'd5, 32'd2, 1'b0, '0);
    // R6 skip
    run_xfer("R6 skip", 64'h0000_0000_0000_0300, 64'h0, 32'd4, 32'd2, 1'b0, '0);
    // R7 item runs out (size 27, offset 12, 20 requested)
    run_xfer("R7 exhaust", 64'h0400, 64'h3000, 32'd20, 32'd2, 1'b0, '0);

    // R8 write error on third byte
    set_sel(16'h0005);
    chk("R11 offset cleared again", {32'd0, item_off}, 64'd0);
    inj_en = 1'b1; inj_addr = 64'h4002;
    run_xfer("R8 mem error", 64'h0500, 64'h4000, 32'd6, 32'd2, 1'b0, '0);
    inj_en = 1'b0;

    // R9 unsupported control
    run_xfer("R9 bad ctrl", 64'h0600, 64'h5000, 32'd3, 32'd1, 1'b0, '0);

    // R10 pointer writes while busy are ignored
    put_rec(64'h0800, 64'h6000, 32'd2, 32'd2);
    run_xfer("R10 busy", 64'h0700, 64'h7000, 32'd10, 32'd2, 1'b1, 64'h0800);
    d = mem[64'h080F];
    chk("R10 second record untouched", {56'd0, d}, 64'd2);

    // R12 read past item end (size 24 for item 0)
    set_sel(16'h0000);
    run_xfer("R6 skip to end", 64'h0900, 64'h0, 32'd24, 32'd2, 1'b0, '0);
    data_read(d);
    chk("R12 past end data", {56'd0, d}, 64'd0);
    chk("R12 past end offset", {32'd0, item_off}, 64'd24);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule